// File: doc/BRIEF.md
# Prioritized Table Lookup Router

This unit keeps a table of 4096 twelve-bit entries and serves two input queues. The table-access queue carries write and read commands. The packet queue carries packets whose header is a table index. A read puts the stored value on a reply queue. A packet is steered to one of four output queues, and the low two bits of the table value pick that queue.

All queues use a valid/ready handshake. A transfer happens on a rising clock edge when both valid and ready are high. Lookups pass through a two-stage pipeline into a four-slot completion buffer, and packets leave that buffer in the order they were admitted.

A fixed-priority scheduler picks one transaction per cycle. A table write outranks a table read, and a table read outranks a packet. A pending write stops new packets from entering and waits for the pipeline to empty, so a lookup never observes a write that happens partway through it.

Top module: `lookup_router`

## Requirements
- R1: A table request with `tbl_write_i`=1 that is accepted stores `tbl_wdata_i` at `tbl_addr_i`. Every read or lookup admitted afterwards sees the new value.
- R2: A table request with `tbl_write_i`=0 returns the entry at `tbl_addr_i` on `rep_data_o`. `rep_valid_o` and `rep_data_o` hold steady until `rep_ready_i` is high. A read is accepted only when no earlier read reply is still outstanding.
- R3: An admitted packet leaves on output queue q, where q equals bits [1:0] of the entry at `pkt_hdr_i`. It carries its header on `out_hdr_o` and its tag on `out_tag_o`.
- R4: A table request is accepted in every cycle in which it can fire, and `pkt_ready_o` is low in that cycle. A read that cannot fire because a reply is outstanding does not block packets.
- R5: A write is accepted only if neither a packet nor a read was admitted on either of the two preceding clock edges. While a write is presented, `pkt_ready_o` stays low. Packets admitted before the write use the old value.
- R6: Packets leave in admission order across all output queues. A stalled head packet holds back every packet behind it.
- R7: At most 4 packets are inside the unit between admission and departure. `pkt_ready_o` is low while 4 are inside.
- R8: At most one bit of `out_valid_o` is high at a time. Once raised, it stays high with stable `out_hdr_o` and `out_tag_o` until the matching `out_ready_i` bit is high.
- R9: After reset, `out_valid_o` and `rep_valid_o` are low and no lookup is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_valid_i | input | 1 | Table request present |
| tbl_ready_o | output | 1 | Table request accepted this cycle |
| tbl_write_i | input | 1 | 1 = write, 0 = read |
| tbl_addr_i | input | 12 | Table index |
| tbl_wdata_i | input | 12 | Value to store |
| rep_valid_o | output | 1 | Read reply present |
| rep_ready_i | input | 1 | Reply consumer ready |
| rep_data_o | output | 12 | Value that was read |
| pkt_valid_i | input | 1 | Packet present |
| pkt_ready_o | output | 1 | Packet accepted this cycle |
| pkt_hdr_i | input | 12 | Packet header (table index) |
| pkt_tag_i | input | 8 | Packet payload tag |
| out_valid_o | output | 4 | Per-queue valid, one-hot or zero |
| out_ready_i | input | 4 | Per-queue ready |
| out_hdr_o | output | 12 | Header of the departing packet |
| out_tag_o | output | 8 | Tag of the departing packet |

## Verification
A directed back-pressure run holds every output queue stalled while packets keep arriving. This shows whether admission stops exactly at four packets in flight and whether the head packet stays frozen. A directed sequence sends a packet, then a write to the same index together with a second packet to that index. This tells a correct drain (the first packet uses the old route, the second the new one) apart from a write that slips in early. Constrained-random traffic on a small set of indices mixes reads, writes, packets and random ready patterns, so priority conflicts and reply stalls occur often. A bench model predicts every ready, reply value, route and departure order.

// File: rtl/lkup_pkg.sv
package lkup_pkg;
  typedef enum logic [1:0] {
    GNT_NONE,
    GNT_WRITE,
    GNT_READ,
    GNT_PKT
  } grant_e;
endpackage

// File: rtl/lkup_sched.sv
module lkup_sched
  import lkup_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tbl_valid_i,
  input  logic   tbl_write_i,
  input  logic   pkt_valid_i,
  input  logic   pipe_busy_i,
  input  logic   reply_free_i,
  input  logic   cb_free_i,
  output logic   tbl_ready_o,
  output logic   pkt_ready_o,
  output grant_e grant_o
);

  logic tbl_claims;

  always_comb begin
    tbl_ready_o = tbl_write_i ? !pipe_busy_i : reply_free_i;
    // a waiting write or a fireable read owns the slot
    tbl_claims  = tbl_valid_i && (tbl_write_i || reply_free_i);
    pkt_ready_o = cb_free_i && !tbl_claims;
    grant_o     = GNT_NONE;
    if (tbl_valid_i && tbl_ready_o) grant_o = tbl_write_i ? GNT_WRITE : GNT_READ;
    else if (pkt_valid_i && pkt_ready_o) grant_o = GNT_PKT;
  end

  p_write_blocks_pkt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_valid_i && tbl_write_i) |-> !pkt_ready_o);

  p_single_grant_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((tbl_valid_i && tbl_ready_o) && (pkt_valid_i && pkt_ready_o)));

endmodule

// File: rtl/lkup_table.sv
module lkup_table #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int ENTRIES = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (re_i) rdata_o <= mem_q[raddr_i];
  end

endmodule

// File: rtl/lkup_cbuf.sv
module lkup_cbuf #(
  parameter int DEPTH  = 4,
  parameter int NQ     = 4,
  parameter int TAG_W  = 8,
  parameter int HDR_W  = 12,
  localparam int QSEL_W = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic              fill_i,
  input  logic [QSEL_W-1:0] fill_port_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [HDR_W-1:0]  fill_hdr_i,
  output logic              free_o,
  output logic [NQ-1:0]     out_valid_o,
  input  logic [NQ-1:0]     out_ready_i,
  output logic [TAG_W-1:0]  out_tag_o,
  output logic [HDR_W-1:0]  out_hdr_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]  done_q;
  logic [QSEL_W-1:0] port_q [DEPTH];
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [HDR_W-1:0]  hdr_q  [DEPTH];
  logic [PTR_W-1:0]  head_q, fill_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              head_done, pop;
  logic [QSEL_W-1:0] head_port;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head_done = done_q[head_q];
  assign head_port = port_q[head_q];
  assign pop       = head_done && out_ready_i[head_port];
  assign free_o    = cnt_q < CNT_W'(DEPTH);
  assign out_tag_o = tag_q[head_q];
  assign out_hdr_o = hdr_q[head_q];

  for (genvar q = 0; q < NQ; q++) begin : g_outq
    assign out_valid_o[q] = head_done && (head_port == QSEL_W'(q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= '0;
      head_q <= '0;
      fill_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (fill_i) begin
        done_q[fill_q] <= 1'b1;
        fill_q         <= nxt(fill_q);
      end
      if (pop) begin
        done_q[head_q] <= 1'b0;
        head_q         <= nxt(head_q);
      end
      case ({alloc_i, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) begin
      port_q[fill_q] <= fill_port_i;
      tag_q[fill_q]  <= fill_tag_i;
      hdr_q[fill_q]  <= fill_hdr_i;
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  p_fill_reserved_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |-> (cnt_q != '0));

  p_onehot_out_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(out_valid_o));

  p_hold_out_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|out_valid_o) && !(|(out_valid_o & out_ready_i)))
      |=> ($stable(out_valid_o) && $stable(out_tag_o) && $stable(out_hdr_o)));

endmodule

// File: rtl/lookup_router.sv
module lookup_router
  import lkup_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 12,
  parameter int TAG_W    = 8,
  parameter int NQ       = 4,
  parameter int CB_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tbl_valid_i,
  output logic              tbl_ready_o,
  input  logic              tbl_write_i,
  input  logic [ADDR_W-1:0] tbl_addr_i,
  input  logic [DATA_W-1:0] tbl_wdata_i,
  output logic              rep_valid_o,
  input  logic              rep_ready_i,
  output logic [DATA_W-1:0] rep_data_o,
  input  logic              pkt_valid_i,
  output logic              pkt_ready_o,
  input  logic [ADDR_W-1:0] pkt_hdr_i,
  input  logic [TAG_W-1:0]  pkt_tag_i,
  output logic [NQ-1:0]     out_valid_o,
  input  logic [NQ-1:0]     out_ready_i,
  output logic [ADDR_W-1:0] out_hdr_o,
  output logic [TAG_W-1:0]  out_tag_o
);

  localparam int QSEL_W = (NQ > 1) ? $clog2(NQ) : 1;

  grant_e            grant;
  logic              s1_v, s1_pkt, s2_v, s2_pkt;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [TAG_W-1:0]  s1_tag, s2_tag;
  logic [DATA_W-1:0] rdata;
  logic              rep_v;
  logic [DATA_W-1:0] rep_d;
  logic              pipe_busy, reply_free, cb_free;

  assign pipe_busy  = s1_v || s2_v;
  assign reply_free = !rep_v && !(s1_v && !s1_pkt) && !(s2_v && !s2_pkt);

  lkup_sched u_sched (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tbl_valid_i  (tbl_valid_i),
    .tbl_write_i  (tbl_write_i),
    .pkt_valid_i  (pkt_valid_i),
    .pipe_busy_i  (pipe_busy),
    .reply_free_i (reply_free),
    .cb_free_i    (cb_free),
    .tbl_ready_o  (tbl_ready_o),
    .pkt_ready_o  (pkt_ready_o),
    .grant_o      (grant)
  );

  lkup_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_table (
    .clk_i   (clk_i),
    .we_i    (grant == GNT_WRITE),
    .waddr_i (tbl_addr_i),
    .wdata_i (tbl_wdata_i),
    .re_i    (s1_v),
    .raddr_i (s1_addr),
    .rdata_o (rdata)
  );

  // two-stage lookup: s1 issues the read, s2 holds returned data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v   <= 1'b0;
      s1_pkt <= 1'b0;
      s2_v   <= 1'b0;
      s2_pkt <= 1'b0;
      rep_v  <= 1'b0;
    end else begin
      s1_v   <= (grant == GNT_READ) || (grant == GNT_PKT);
      s1_pkt <= (grant == GNT_PKT);
      s2_v   <= s1_v;
      s2_pkt <= s1_pkt;
      if (s2_v && !s2_pkt) rep_v <= 1'b1;
      else if (rep_ready_i) rep_v <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    s1_addr <= (grant == GNT_PKT) ? pkt_hdr_i : tbl_addr_i;
    s1_tag  <= pkt_tag_i;
    s2_addr <= s1_addr;
    s2_tag  <= s1_tag;
    if (s2_v && !s2_pkt) rep_d <= rdata;
  end

  assign rep_valid_o = rep_v;
  assign rep_data_o  = rep_d;

  lkup_cbuf #(
    .DEPTH (CB_DEPTH),
    .NQ    (NQ),
    .TAG_W (TAG_W),
    .HDR_W (ADDR_W)
  ) u_cbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_i     (grant == GNT_PKT),
    .fill_i      (s2_v && s2_pkt),
    .fill_port_i (rdata[QSEL_W-1:0]),
    .fill_tag_i  (s2_tag),
    .fill_hdr_i  (s2_addr),
    .free_o      (cb_free),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_tag_o   (out_tag_o),
    .out_hdr_o   (out_hdr_o)
  );

  p_write_drained_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_valid_i && tbl_ready_o && tbl_write_i) |-> (!s1_v && !s2_v));

  p_reply_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rep_valid_o && !rep_ready_i) |=> (rep_valid_o && $stable(rep_data_o)));

  p_read_no_clobber_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_v && !s2_pkt) |-> !rep_valid_o);

endmodule

// File: tb/lookup_router_tb.sv
module lookup_router_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tbl_valid_i = 1'b0, tbl_write_i = 1'b0;
  logic [11:0] tbl_addr_i = '0, tbl_wdata_i = '0;
  logic        tbl_ready_o;
  logic        rep_valid_o, rep_ready_i = 1'b0;
  logic [11:0] rep_data_o;
  logic        pkt_valid_i = 1'b0, pkt_ready_o;
  logic [11:0] pkt_hdr_i = '0;
  logic [7:0]  pkt_tag_i = '0;
  logic [3:0]  out_valid_o, out_ready_i = '0;
  logic [11:0] out_hdr_o;
  logic [7:0]  out_tag_o;

  lookup_router dut_i (.*);

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  logic [11:0] mdl [4096];
  logic [1:0]  ep_port [256];
  logic [7:0]  ep_tag [256];
  logic [11:0] ep_hdr [256];
  int          ep_head = 0, ep_tail = 0;
  logic [11:0] rq_val [256];
  int          rq_head = 0, rq_tail = 0;
  int          outst = 0;
  bit          adm1 = 0, adm2 = 0, last_tacc = 0, last_pacc = 0;
  bit          prev_hold = 0;
  logic [3:0]  prev_v;
  logic [7:0]  prev_tag;
  logic [7:0]  tag_ctr = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [11:0] pick();
    int i = int'($urandom % 32);
    return (i < 16) ? 12'(i) : 12'(4064 + i);
  endfunction

  task automatic tick();
    bit exp_tr, exp_pr, tacc, pacc;
    int cnt, port;
    #1;
    // readiness as predicted from requirements
    if (tbl_valid_i) begin
      exp_tr = tbl_write_i ? !(adm1 || adm2) : (rq_tail == rq_head);
      check(tbl_ready_o == exp_tr, tbl_write_i ? "R5 write ready" : "R4 read ready",
            int'(tbl_ready_o), int'(exp_tr));
    end
    if (pkt_valid_i) begin
      exp_pr = (outst < 4) && !(tbl_valid_i && (tbl_write_i || rq_tail == rq_head));
      check(pkt_ready_o == exp_pr,
            (outst >= 4) ? "R7 full" : (tbl_valid_i && tbl_write_i) ? "R5 blocked" : "R4 pkt ready",
            int'(pkt_ready_o), int'(exp_pr));
    end
    tacc = tbl_valid_i && tbl_ready_o;
    pacc = pkt_valid_i && pkt_ready_o;
    // outputs
    cnt = $countones(out_valid_o);
    check(cnt <= 1, "R8 onehot", cnt, 1);
    if (prev_hold) begin
      check(out_valid_o == prev_v, "R8 hold valid", int'(out_valid_o), int'(prev_v));
      check(out_tag_o == prev_tag, "R8 hold tag", int'(out_tag_o), int'(prev_tag));
    end
    prev_hold = 1'b0;
    if (cnt == 1) begin
      port = 0;
      for (int q = 0; q < 4; q++) if (out_valid_o[q]) port = q;
      if (ep_head == ep_tail) check(1'b0, "R6 unexpected packet", port, -1);
      else begin
        check(port == int'(ep_port[ep_head % 256]), "R3 route", port, int'(ep_port[ep_head % 256]));
        check(out_tag_o == ep_tag[ep_head % 256], "R6 order", int'(out_tag_o), int'(ep_tag[ep_head % 256]));
        check(out_hdr_o == ep_hdr[ep_head % 256], "R3 hdr", int'(out_hdr_o), int'(ep_hdr[ep_head % 256]));
        if (out_ready_i[port]) begin ep_head++; outst--; end
        else begin prev_hold = 1'b1; prev_v = out_valid_o; prev_tag = out_tag_o; end
      end
    end
    if (rep_valid_o) begin
      if (rq_head == rq_tail) check(1'b0, "R2 unexpected reply", int'(rep_data_o), -1);
      else begin
        check(rep_data_o == rq_val[rq_head % 256], "R2 reply", int'(rep_data_o), int'(rq_val[rq_head % 256]));
        if (rep_ready_i) rq_head++;
      end
    end
    // model updates for accepted transactions (R1)
    if (tacc) begin
      if (tbl_write_i) mdl[tbl_addr_i] = tbl_wdata_i;
      else begin rq_val[rq_tail % 256] = mdl[tbl_addr_i]; rq_tail++; end
    end
    if (pacc) begin
      ep_port[ep_tail % 256] = mdl[pkt_hdr_i][1:0];
      ep_tag[ep_tail % 256]  = pkt_tag_i;
      ep_hdr[ep_tail % 256]  = pkt_hdr_i;
      ep_tail++;
      outst++;
    end
    adm2 = adm1;
    adm1 = pacc || (tacc && !tbl_write_i);
    last_tacc = tacc;
    last_pacc = pacc;
    @(negedge clk_i);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    check(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    void'($urandom(32'd20241));
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check(out_valid_o == '0, "R9 out_valid in reset", int'(out_valid_o), 0);
    check(rep_valid_o == 1'b0, "R9 rep_valid in reset", int'(rep_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(out_valid_o == '0, "R9 out_valid after reset", int'(out_valid_o), 0);
    check(pkt_ready_o == 1'b1, "R9 idle pkt ready", int'(pkt_ready_o), 1);

    // R1 preload the index set
    out_ready_i = 4'hF;
    rep_ready_i = 1'b1;
    for (int i = 0; i < 32; i++) begin
      tbl_valid_i = 1'b1; tbl_write_i = 1'b1;
      tbl_addr_i  = (i < 16) ? 12'(i) : 12'(4064 + i);
      tbl_wdata_i = 12'($urandom);
      do tick(); while (!last_tacc);
    end
    tbl_valid_i = 1'b0;

    // R2 directed read of the top entry
    tbl_valid_i = 1'b1; tbl_write_i = 1'b0; tbl_addr_i = 12'd4095;
    do tick(); while (!last_tacc);
    tbl_valid_i = 1'b0;
    repeat (4) tick();

    // R7/R8 back-pressure: all outputs stalled
    out_ready_i = 4'h0;
    for (int i = 0; i < 12; i++) begin
      if (!pkt_valid_i || last_pacc) begin
        pkt_valid_i = 1'b1; pkt_hdr_i = pick(); pkt_tag_i = tag_ctr++;
      end
      tick();
    end
    check(outst == 4, "R7 occupancy", outst, 4);
    pkt_valid_i = 1'b0;
    out_ready_i = 4'hF;
    repeat (8) tick();

    // R5 directed: packet, then write to its index with a second packet
    pkt_valid_i = 1'b1; pkt_hdr_i = 12'd5; pkt_tag_i = tag_ctr++;
    do tick(); while (!last_pacc);
    pkt_tag_i = tag_ctr++;
    tbl_valid_i = 1'b1; tbl_write_i = 1'b1; tbl_addr_i = 12'd5;
    tbl_wdata_i = mdl[5] ^ 12'h001;
    do tick(); while (!last_tacc);
    tbl_valid_i = 1'b0;
    do tick(); while (!last_pacc);
    pkt_valid_i = 1'b0;
    repeat (8) tick();

    // constrained random mix
    for (int c = 0; c < 3000; c++) begin
      if (!tbl_valid_i || last_tacc) begin
        tbl_valid_i = ($urandom % 3) == 0;
        tbl_write_i = ($urandom % 3) == 0;
        tbl_addr_i  = pick();
        tbl_wdata_i = 12'($urandom);
      end
      if (!pkt_valid_i || last_pacc) begin
        pkt_valid_i = ($urandom % 2) == 0;
        pkt_hdr_i   = pick();
        pkt_tag_i   = tag_ctr++;
      end
      for (int q = 0; q < 4; q++) out_ready_i[q] = ($urandom % 4) != 0;
      rep_ready_i = ($urandom % 3) != 0;
      tick();
    end

    // drain
    tbl_valid_i = 1'b0; pkt_valid_i = 1'b0;
    out_ready_i = 4'hF; rep_ready_i = 1'b1;
    repeat (20) tick();
    check(ep_head == ep_tail, "R6 all packets left", ep_tail - ep_head, 0);
    check(rq_head == rq_tail, "R2 all replies left", rq_tail - rq_head, 0);
    check(out_valid_o == '0, "R8 idle outputs", int'(out_valid_o), 0);
    report();
  end

endmodule